// File: doc/BRIEF.md
# Word-Serial Modular Add/Subtract Sequencer

This unit is the general-purpose modular-arithmetic engine placed between a host controller and two memory banks that also feed two modular multipliers. It executes modular addition, modular subtraction and bank-to-bank copy commands one 32-bit word at a time, least significant word first. It drives the second port of both banks at once. For each addition or subtraction it computes the unreduced result and the corrected result in the same pass and writes them to different banks. Once the final carry or borrow is known, it copies whichever result is correct over the other, so both banks end up holding the same value.

The host owns the bank ports whenever the unit is idle. While the unit executes, `busy_o` is high and the unit drives the ports itself, so host writes cannot reach the banks. Multiplier start commands also arrive on the command port. They are forwarded as a one-cycle start pulse to the selected multiplier, and the multipliers' completion flags are registered back to the host. The host therefore never drives a multiplier directly.

Top module: `modarith_seq`

## Requirements
- R1: After synchronous reset, `busy_o`, `done_o`, `mult_start_o` and `host_mult_done_o` are all low, and `bank_we_o` is low while `host_we_i` is low.
- R2: `cmd_op_i` is encoded as 2'b00 add, 2'b01 subtract, 2'b10 copy and 2'b11 multiplier start. A command is taken only in a cycle where `cmd_valid_i` is high and `busy_o` is low. A command offered while `busy_o` is high is dropped and has no effect on the banks.
- R3: For an add of N words, operand A is read from bank 0 at `cmd_a_addr_i`+i, operand B from bank 1 at `cmd_b_addr_i`+i, and the modulus from bank 0 at `cmd_m_addr_i`+i, with word 0 least significant. The sum modulo 2^(32N) is written to bank 0 at `cmd_d_addr_i`+i, and the sum minus the modulus modulo 2^(32N) is written to bank 1 at the same address.
- R4: When an add finishes, both banks at the destination hold the reduced value if the sum carried out of word N-1 or if subtracting the modulus did not borrow. Otherwise both banks hold the plain sum. For A,B < M, this equals (A+B) mod M.
- R5: For a subtract, bank 0 receives A−B modulo 2^(32N) and bank 1 receives A−B+M. When the command finishes, both banks hold the raw difference if A−B did not borrow, and the corrected value if it did.
- R6: Carries and borrows pass from word i to word i+1 through registered flags, so carry and borrow chains that run across several words give exact multiword results.
- R7: A copy with `cmd_sel_i`=0 moves N words from bank 0 at `cmd_a_addr_i` to bank 1 at `cmd_d_addr_i`. With `cmd_sel_i`=1 it moves them from bank 1 to bank 0.
- R8: `busy_o` rises in the cycle after a command is taken. It stays high for exactly 5N+1 cycles for an add or subtract, and for exactly 2N+1 cycles for a copy.
- R9: `done_o` is high for exactly one cycle, which is the last cycle with `busy_o` high. `busy_o` is low in the cycle that follows.
- R10: While `busy_o` is low, host writes through `host_addr_i`/`host_we_i`/`host_wdata_i` reach the banks, with bit k of `host_we_i` selecting bank k. While `busy_o` is high, host writes do not reach the banks.
- R11: A multiplier start command produces a one-cycle pulse on bit `cmd_sel_i` of `mult_start_o`, one cycle after the command is taken. `busy_o` stays low and `done_o` is not raised.
- R12: `host_mult_done_o` equals `mult_done_i` delayed by one cycle, whether or not the unit is busy.
- R13: Operand lengths from 1 up to 96 words (3072 bits) are supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_op_i | input | 2 | Command code |
| cmd_sel_i | input | 1 | Copy direction, or multiplier index |
| cmd_a_addr_i | input | 9 | Base word address of operand A, or copy source |
| cmd_b_addr_i | input | 9 | Base word address of operand B in bank 1 |
| cmd_m_addr_i | input | 9 | Base word address of the modulus in bank 0 |
| cmd_d_addr_i | input | 9 | Base word address of the destination |
| cmd_len_i | input | 7 | Length in words |
| busy_o | output | 1 | Unit executing, owns the bank ports |
| done_o | output | 1 | One-cycle completion pulse |
| host_addr_i | input | 9 | Host bank address |
| host_we_i | input | 2 | Host write enable, one bit per bank |
| host_wdata_i | input | 32 | Host write data |
| bank_addr_o | output | 2x9 | Address to each bank's second port |
| bank_we_o | output | 2 | Write enable to each bank |
| bank_wdata_o | output | 2x32 | Write data to each bank |
| bank_rdata_i | input | 2x32 | Read data from each bank, one cycle after the address |
| mult_start_o | output | 2 | Start pulse for each multiplier |
| mult_done_i | input | 2 | Completion flag from each multiplier |
| host_mult_done_o | output | 2 | Registered completion flags to the host |

## Verification
Two functions can overlap in one cycle: relaying a multiplier completion, and executing an add or subtract sequence. The bench drives `mult_done_i` in the middle of an addition. It checks that the flag reaches `host_mult_done_o` on the next cycle and that the arithmetic result and the busy length are unchanged. The bench also offers a second command and a host write while a subtraction is running. It checks that neither one touches the banks, and that `busy_o` drops exactly once.

// File: rtl/modarith_pkg.sv
package modarith_pkg;

    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 9;
    localparam int MAX_WORDS = 96;
    localparam int LEN_W     = $clog2(MAX_WORDS + 1);
    localparam int NBANK     = 2;
    localparam int NMULT     = 2;
    localparam int MSEL_W    = (NMULT > 1) ? $clog2(NMULT) : 1;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LEN_W-1:0]  len_t;

    typedef enum logic [1:0] {
        OP_ADD    = 2'b00,
        OP_SUB    = 2'b01,
        OP_COPY   = 2'b10,
        OP_MSTART = 2'b11
    } op_e;

    typedef struct packed {
        op_e   op;
        logic  sel;
        addr_t a_addr;
        addr_t b_addr;
        addr_t m_addr;
        addr_t d_addr;
        len_t  len;
    } cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_AB,
        ST_RD_M,
        ST_WR,
        ST_CP_RD,
        ST_CP_WR,
        ST_FINISH
    } state_e;

    typedef struct packed {
        word_t raw;
        word_t alt;
        logic  c_raw;
        logic  c_alt;
    } alu_out_t;

    // Word add with carry in; MSB of the result is the carry out.
    function automatic logic [WORD_W:0] add_c(word_t x, word_t y, logic ci);
        return {1'b0, x} + {1'b0, y} + {{WORD_W{1'b0}}, ci};
    endfunction

    // Word subtract with borrow in; MSB of the result is the borrow out.
    function automatic logic [WORD_W:0] sub_b(word_t x, word_t y, logic bi);
        return {1'b0, x} - {1'b0, y} - {{WORD_W{1'b0}}, bi};
    endfunction

endpackage

// File: rtl/modarith_word_alu.sv
module modarith_word_alu
    import modarith_pkg::*;
(
    input  op_e      op_i,
    input  word_t    a_i,
    input  word_t    b_i,
    input  word_t    m_i,
    input  logic     c_raw_i,
    input  logic     c_alt_i,
    output alu_out_t res_o
);
    logic [WORD_W:0] first;
    logic [WORD_W:0] second;

    always_comb begin
        if (op_i == OP_SUB) begin
            first  = sub_b(a_i, b_i, c_raw_i);
            second = add_c(first[WORD_W-1:0], m_i, c_alt_i);
        end else begin
            first  = add_c(a_i, b_i, c_raw_i);
            second = sub_b(first[WORD_W-1:0], m_i, c_alt_i);
        end
        res_o.raw   = first[WORD_W-1:0];
        res_o.alt   = second[WORD_W-1:0];
        res_o.c_raw = first[WORD_W];
        res_o.c_alt = second[WORD_W];
    end
endmodule

// File: rtl/modarith_port_mux.sv
module modarith_port_mux
    import modarith_pkg::*;
(
    input  logic                          busy_i,
    input  addr_t                         host_addr_i,
    input  logic [NBANK-1:0]              host_we_i,
    input  word_t                         host_wdata_i,
    input  logic [NBANK-1:0][ADDR_W-1:0]  seq_addr_i,
    input  logic [NBANK-1:0]              seq_we_i,
    input  logic [NBANK-1:0][WORD_W-1:0]  seq_wdata_i,
    output logic [NBANK-1:0][ADDR_W-1:0]  bank_addr_o,
    output logic [NBANK-1:0]              bank_we_o,
    output logic [NBANK-1:0][WORD_W-1:0]  bank_wdata_o
);
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign bank_addr_o[b]  = busy_i ? seq_addr_i[b]  : host_addr_i;
        assign bank_we_o[b]    = busy_i ? seq_we_i[b]    : host_we_i[b];
        assign bank_wdata_o[b] = busy_i ? seq_wdata_i[b] : host_wdata_i;
    end
endmodule

// File: rtl/modarith_mult_relay.sv
module modarith_mult_relay
    import modarith_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_i,
    input  logic [MSEL_W-1:0] sel_i,
    input  logic [NMULT-1:0]  done_i,
    output logic [NMULT-1:0]  start_o,
    output logic [NMULT-1:0]  status_o
);
    for (genvar k = 0; k < NMULT; k++) begin : g_mult
        always_ff @(posedge clk) begin
            if (rst) begin
                start_o[k]  <= 1'b0;
                status_o[k] <= 1'b0;
            end else begin
                start_o[k]  <= issue_i && (sel_i == MSEL_W'(k));
                status_o[k] <= done_i[k];
            end
        end
    end
endmodule

// File: rtl/modarith_seq.sv
module modarith_seq
    import modarith_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cmd_valid_i,
    input  logic [1:0]                    cmd_op_i,
    input  logic                          cmd_sel_i,
    input  logic [ADDR_W-1:0]             cmd_a_addr_i,
    input  logic [ADDR_W-1:0]             cmd_b_addr_i,
    input  logic [ADDR_W-1:0]             cmd_m_addr_i,
    input  logic [ADDR_W-1:0]             cmd_d_addr_i,
    input  logic [LEN_W-1:0]              cmd_len_i,
    output logic                          busy_o,
    output logic                          done_o,
    input  logic [ADDR_W-1:0]             host_addr_i,
    input  logic [NBANK-1:0]              host_we_i,
    input  logic [WORD_W-1:0]             host_wdata_i,
    output logic [NBANK-1:0][ADDR_W-1:0]  bank_addr_o,
    output logic [NBANK-1:0]              bank_we_o,
    output logic [NBANK-1:0][WORD_W-1:0]  bank_wdata_o,
    input  logic [NBANK-1:0][WORD_W-1:0]  bank_rdata_i,
    output logic [NMULT-1:0]              mult_start_o,
    input  logic [NMULT-1:0]              mult_done_i,
    output logic [NMULT-1:0]              host_mult_done_o
);
    state_e   st_q;
    cmd_t     cmd_q;
    len_t     idx_q;
    word_t    a_q, b_q;
    logic     c_raw_q, c_alt_q;
    logic     cp_from_q;
    addr_t    cp_base_q;
    alu_out_t alu_res;
    logic     last_word, pick_alt, take, issue_mult;
    op_e      in_op;

    logic [NBANK-1:0][ADDR_W-1:0] seq_addr;
    logic [NBANK-1:0]             seq_we;
    logic [NBANK-1:0][WORD_W-1:0] seq_wdata;

    assign in_op      = op_e'(cmd_op_i);
    assign take       = cmd_valid_i && (st_q == ST_IDLE);
    assign issue_mult = take && (in_op == OP_MSTART);
    assign busy_o     = (st_q != ST_IDLE);
    assign done_o     = (st_q == ST_FINISH);
    assign last_word  = (idx_q == len_t'(cmd_q.len - 1'b1));
    // Correct value lives in bank 1 (the corrected candidate) when true.
    assign pick_alt   = (cmd_q.op == OP_SUB) ? alu_res.c_raw
                                             : (alu_res.c_raw || !alu_res.c_alt);

    modarith_word_alu u_alu (
        .op_i    (cmd_q.op),
        .a_i     (a_q),
        .b_i     (b_q),
        .m_i     (bank_rdata_i[0]),
        .c_raw_i (c_raw_q),
        .c_alt_i (c_alt_q),
        .res_o   (alu_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            cmd_q     <= '0;
            idx_q     <= '0;
            a_q       <= '0;
            b_q       <= '0;
            c_raw_q   <= 1'b0;
            c_alt_q   <= 1'b0;
            cp_from_q <= 1'b0;
            cp_base_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (take && in_op != OP_MSTART) begin
                        cmd_q     <= '{op: in_op, sel: cmd_sel_i, a_addr: cmd_a_addr_i,
                                       b_addr: cmd_b_addr_i, m_addr: cmd_m_addr_i,
                                       d_addr: cmd_d_addr_i, len: cmd_len_i};
                        idx_q     <= '0;
                        c_raw_q   <= 1'b0;
                        c_alt_q   <= 1'b0;
                        cp_from_q <= cmd_sel_i;
                        cp_base_q <= cmd_a_addr_i;
                        if (cmd_len_i == '0)
                            st_q <= ST_FINISH;
                        else if (in_op == OP_COPY)
                            st_q <= ST_CP_RD;
                        else
                            st_q <= ST_RD_AB;
                    end
                end
                ST_RD_AB: st_q <= ST_RD_M;
                ST_RD_M: begin
                    a_q  <= bank_rdata_i[0];
                    b_q  <= bank_rdata_i[1];
                    st_q <= ST_WR;
                end
                ST_WR: begin
                    c_raw_q <= alu_res.c_raw;
                    c_alt_q <= alu_res.c_alt;
                    if (last_word) begin
                        idx_q     <= '0;
                        cp_from_q <= pick_alt;
                        cp_base_q <= cmd_q.d_addr;
                        st_q      <= ST_CP_RD;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                        st_q  <= ST_RD_AB;
                    end
                end
                ST_CP_RD: st_q <= ST_CP_WR;
                ST_CP_WR: begin
                    if (last_word) begin
                        st_q <= ST_FINISH;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                        st_q  <= ST_CP_RD;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        seq_addr  = '0;
        seq_we    = '0;
        seq_wdata = '0;
        case (st_q)
            ST_RD_AB: begin
                seq_addr[0] = cmd_q.a_addr + ADDR_W'(idx_q);
                seq_addr[1] = cmd_q.b_addr + ADDR_W'(idx_q);
            end
            ST_RD_M: seq_addr[0] = cmd_q.m_addr + ADDR_W'(idx_q);
            ST_WR: begin
                seq_addr[0]  = cmd_q.d_addr + ADDR_W'(idx_q);
                seq_addr[1]  = cmd_q.d_addr + ADDR_W'(idx_q);
                seq_we       = '1;
                seq_wdata[0] = alu_res.raw;
                seq_wdata[1] = alu_res.alt;
            end
            ST_CP_RD: seq_addr[cp_from_q] = cp_base_q + ADDR_W'(idx_q);
            ST_CP_WR: begin
                seq_addr[~cp_from_q]  = cmd_q.d_addr + ADDR_W'(idx_q);
                seq_we[~cp_from_q]    = 1'b1;
                seq_wdata[~cp_from_q] = bank_rdata_i[cp_from_q];
            end
            default: ;
        endcase
    end

    modarith_port_mux u_mux (
        .busy_i       (busy_o),
        .host_addr_i  (host_addr_i),
        .host_we_i    (host_we_i),
        .host_wdata_i (host_wdata_i),
        .seq_addr_i   (seq_addr),
        .seq_we_i     (seq_we),
        .seq_wdata_i  (seq_wdata),
        .bank_addr_o  (bank_addr_o),
        .bank_we_o    (bank_we_o),
        .bank_wdata_o (bank_wdata_o)
    );

    modarith_mult_relay u_relay (
        .clk      (clk),
        .rst      (rst),
        .issue_i  (issue_mult),
        .sel_i    (MSEL_W'(cmd_sel_i)),
        .done_i   (mult_done_i),
        .start_o  (mult_start_o),
        .status_o (host_mult_done_o)
    );
endmodule

// File: rtl/modarith_seq_chk.sv
module modarith_seq_chk
    import modarith_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic             busy,
    input logic             done,
    input logic [NMULT-1:0] mult_start
);
    a_r9_done_inside_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_busy_ends_after_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done));

    a_r8_take_raises_busy: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && cmd_op != 2'b11) |=> busy);

    a_r11_start_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mult_start));

    a_r11_start_has_cause: assert property (@(posedge clk) disable iff (rst)
        (mult_start != '0) |-> ($past(cmd_valid && !busy && cmd_op == 2'b11) && !busy));
endmodule

bind modarith_seq modarith_seq_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid_i),
    .cmd_op     (cmd_op_i),
    .busy       (busy_o),
    .done       (done_o),
    .mult_start (mult_start_o)
);

// File: tb/modarith_seq_tb_top.sv
module modarith_seq_tb_top;
    import modarith_pkg::*;

    typedef logic [3103:0] big_t;
    typedef struct {
        int    bank;
        int    addr;
        word_t val;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic cmd_sel = 1'b0;
    addr_t cmd_a = '0, cmd_b = '0, cmd_m = '0, cmd_d = '0;
    len_t cmd_len = '0;
    logic busy, done;
    addr_t host_addr = '0;
    logic [NBANK-1:0] host_we = '0;
    word_t host_wdata = '0;
    logic [NBANK-1:0][ADDR_W-1:0] bank_addr;
    logic [NBANK-1:0] bank_we;
    logic [NBANK-1:0][WORD_W-1:0] bank_wdata;
    logic [NBANK-1:0][WORD_W-1:0] bank_rdata;
    logic [NMULT-1:0] mult_start;
    logic [NMULT-1:0] mult_done = '0;
    logic [NMULT-1:0] host_mult_done;

    word_t mem0 [512];
    word_t mem1 [512];
    exp_t  sbq [$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 0;

    always #4 clk = ~clk;

    modarith_seq dut_i (
        .clk(clk), .rst(rst),
        .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_sel_i(cmd_sel),
        .cmd_a_addr_i(cmd_a), .cmd_b_addr_i(cmd_b), .cmd_m_addr_i(cmd_m),
        .cmd_d_addr_i(cmd_d), .cmd_len_i(cmd_len),
        .busy_o(busy), .done_o(done),
        .host_addr_i(host_addr), .host_we_i(host_we), .host_wdata_i(host_wdata),
        .bank_addr_o(bank_addr), .bank_we_o(bank_we), .bank_wdata_o(bank_wdata),
        .bank_rdata_i(bank_rdata),
        .mult_start_o(mult_start), .mult_done_i(mult_done),
        .host_mult_done_o(host_mult_done)
    );

    // Bank models: one port each, read data one cycle after the address.
    always @(posedge clk) begin
        if (bank_we[0]) mem0[bank_addr[0]] <= bank_wdata[0];
        if (bank_we[1]) mem1[bank_addr[1]] <= bank_wdata[1];
        bank_rdata[0] <= mem0[bank_addr[0]];
        bank_rdata[1] <= mem1[bank_addr[1]];
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic word_t mem_rd(input int bank, input int addr);
        return (bank != 0) ? mem1[addr] : mem0[addr];
    endfunction

    function automatic big_t gen(input int seed, input int n);
        big_t v = '0;
        for (int i = 0; i < n; i++)
            v[32*i +: 32] = (32'(seed) * 32'h9E3779B9) ^ (32'(i + 1) * 32'h85EBCA6B) ^ 32'h5BD1E995;
        v[32*n-1] = 1'b1;
        return v;
    endfunction

    task automatic host_wr(input logic [1:0] mask, input int addr, input word_t v);
        host_addr  = addr_t'(addr);
        host_we    = mask;
        host_wdata = v;
        @(negedge clk);
        host_we = '0;
    endtask

    task automatic load_big(input int bank, input int addr, input int n, input big_t v);
        for (int i = 0; i < n; i++)
            host_wr((bank != 0) ? 2'b10 : 2'b01, addr + i, v[32*i +: 32]);
    endtask

    // Scoreboard monitor: when done pulses, all pushed bank contents are final.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (!rst && done) begin
                while (sbq.size() > 0) begin
                    e = sbq.pop_front();
                    check(mem_rd(e.bank, e.addr) == e.val, e.tag, "bank word",
                          mem_rd(e.bank, e.addr), e.val);
                end
            end
        end
    end

    // Driver: issues one command, counts busy cycles, applies injections.
    // inj bit0: command offered while busy, bit1: host write while busy,
    // bit2: multiplier status change while busy.
    task automatic run_cmd(input logic [1:0] op, input logic sel, input int a, input int b,
                           input int m, input int d, input int n, input int exp_cyc,
                           input int mid, input big_t raw, input big_t alt,
                           input string mtag, input int inj);
        int cnt = 0;
        int done_at = 0;
        cmd_op = op; cmd_sel = sel;
        cmd_a = addr_t'(a); cmd_b = addr_t'(b); cmd_m = addr_t'(m); cmd_d = addr_t'(d);
        cmd_len = len_t'(n);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) begin
            cnt++;
            if (done) done_at = cnt;
            if (mid > 0 && cnt == mid) begin
                for (int i = 0; i < n; i++) begin
                    check(mem0[d+i] == raw[32*i +: 32], mtag, "unreduced word", mem0[d+i], raw[32*i +: 32]);
                    check(mem1[d+i] == alt[32*i +: 32], mtag, "corrected word", mem1[d+i], alt[32*i +: 32]);
                end
            end
            if (inj[0] && cnt == 2) begin
                cmd_op = 2'b10; cmd_sel = 1'b0; cmd_a = '0; cmd_d = addr_t'(490);
                cmd_len = len_t'(4); cmd_valid = 1'b1;
            end
            if (inj[0] && cnt == 3) cmd_valid = 1'b0;
            if (inj[1] && cnt == 3) begin
                host_addr = addr_t'(500); host_wdata = 32'hDEADBEEF; host_we = 2'b11;
            end
            if (inj[1] && cnt == 4) host_we = '0;
            if (inj[2] && cnt == 5) mult_done = 2'b10;
            if (inj[2] && cnt == 6) begin
                check(host_mult_done == 2'b10, "R12", "relay while busy", host_mult_done, 2'b10);
                mult_done = '0;
            end
            @(negedge clk);
        end
        check(cnt == exp_cyc, "R8", "busy cycles", cnt, exp_cyc);
        check(done_at == cnt && cnt > 0, "R9", "done in last busy cycle", done_at, cnt);
    endtask

    task automatic do_arith(input logic [1:0] op, input int n, input big_t A, input big_t B,
                            input big_t M, input string ftag, input int inj);
        big_t mask = (big_t'(1) << (32*n)) - 1;
        big_t raw, alt, fin, s;
        string mtag;
        if (op == 2'b00) begin
            s   = A + B;
            raw = s & mask;
            alt = (s - M) & mask;
            fin = (s >= M) ? alt : raw;
            mtag = "R3";
        end else begin
            raw = (A - B) & mask;
            alt = (A - B + M) & mask;
            fin = (A >= B) ? raw : alt;
            mtag = "R5";
        end
        load_big(0, 0, n, A);
        load_big(1, 128, n, B);
        load_big(0, 256, n, M);
        for (int i = 0; i < n; i++) begin
            sbq.push_back('{bank: 0, addr: 384 + i, val: fin[32*i +: 32], tag: ftag});
            sbq.push_back('{bank: 1, addr: 384 + i, val: fin[32*i +: 32], tag: ftag});
        end
        run_cmd(op, 1'b0, 0, 128, 256, 384, n, 5*n + 1, 3*n + 1, raw, alt, mtag, inj);
    endtask

    task automatic do_copy(input logic sel, input int src, input int d, input int n);
        for (int i = 0; i < n; i++)
            sbq.push_back('{bank: sel ? 0 : 1, addr: d + i,
                            val: mem_rd(sel ? 1 : 0, src + i), tag: "R7"});
        run_cmd(2'b10, sel, src, 0, 0, d, n, 2*n + 1, 0, '0, '0, "R7", 0);
    endtask

    task automatic do_mstart(input logic sel);
        logic [1:0] want;
        want = sel ? 2'b10 : 2'b01;
        cmd_op = 2'b11; cmd_sel = sel; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(mult_start == want, "R11", "start pulse", mult_start, want);
        check(!busy && !done, "R11", "no busy/done", {busy, done}, 0);
        @(negedge clk);
        check(mult_start == 2'b00, "R11", "pulse length", mult_start, 0);
    endtask

    initial begin
        big_t M, A, B;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
        check(mult_start == '0 && host_mult_done == '0, "R1", "multiplier outputs", {mult_start, host_mult_done}, 0);
        check(bank_we == '0, "R1", "bank write enables", bank_we, 0);

        for (int i = 490; i < 502; i++) host_wr(2'b11, i, '0);
        host_wr(2'b01, 501, 32'h12345678);
        check(mem0[501] == 32'h12345678 && mem1[501] == 32'h0, "R10", "idle host write",
              mem0[501], 32'h12345678);

        // Add without reduction, multiplier status toggled mid-run
        M = gen(3, 4);
        do_arith(2'b00, 4, M >> 2, M >> 3, M, "R4", 4);
        // Add where sum >= modulus, no carry out
        do_arith(2'b00, 4, M - 5, big_t'(100), M, "R4", 0);
        // Add with carry out of the top word
        M = (big_t'(1) << 128) - 3;
        do_arith(2'b00, 4, M - 1, M - 2, M, "R4", 0);
        // Carry chain over three words
        M = (big_t'(1) << 128) - 1;
        do_arith(2'b00, 4, (big_t'(1) << 96) - 1, big_t'(1), M, "R6", 0);
        // Subtract without borrow
        M = gen(5, 4);
        do_arith(2'b01, 4, M - 1, big_t'(7), M, "R5", 0);
        // Subtract with borrow; command and host write offered while busy
        do_arith(2'b01, 4, big_t'(3), big_t'(10), M, "R5", 3);
        check(mem0[500] == 32'h0 && mem1[500] == 32'h0, "R10", "host write while busy",
              {mem0[500], mem1[500]}, 0);
        for (int i = 0; i < 4; i++)
            check(mem1[490+i] == 32'h0, "R2", "dropped copy target", mem1[490+i], 0);
        for (int k = 0; k < 3; k++) begin
            check(!busy, "R2", "no second run", busy, 0);
            @(negedge clk);
        end
        // Borrow chain over three words
        M = (big_t'(1) << 128) - 1;
        do_arith(2'b01, 4, big_t'(1) << 96, big_t'(1), M, "R6", 0);

        do_copy(1'b0, 0, 300, 4);
        do_copy(1'b1, 128, 310, 4);

        do_mstart(1'b0);
        do_mstart(1'b1);

        mult_done = 2'b01;
        @(negedge clk);
        check(host_mult_done == 2'b01, "R12", "relay while idle", host_mult_done, 2'b01);
        mult_done = 2'b00;
        @(negedge clk);
        check(host_mult_done == 2'b00, "R12", "relay clear", host_mult_done, 0);

        // Longest operand: 96 words
        M = gen(7, 96);
        do_arith(2'b00, 96, M - 1, big_t'(2), M, "R13", 0);

        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule